// File: doc/BRIEF.md
# Raster Timing Generator for Clocked Video Output

This block produces the pixel-clock-domain raster timing for a video output that carries its synchronization on separate wires. A video mode is supplied on parallel inputs: active width, horizontal sync start and end, total samples per line, active height, vertical sync start and end, line totals for the two fields, and an interlace flag. From these the block drives data-valid, horizontal and vertical blanking, horizontal and vertical sync, and a field flag. Every output comes from a register, so each output reflects the raster position that the counters held one clock earlier.

A pulse on `mode_load` captures the mode inputs as a pending mode. The pending mode takes effect only at the next frame boundary. `mode_change` is high for a single cycle: the cycle that carries the last sample of the old frame, just before the first sample of the new timing.

Around the raster the block also provides several helper outputs:
- a one-cycle start-of-frame pulse at a programmable line and sample of field 0;
- a lock flag that shows when that pulse can be trusted;
- a free-running divided clock that serves as a reference for an external PLL;
- a copy of an asynchronous sticky underflow bit, synchronized into the pixel clock domain.

Top module: `vid_raster_gen`

## Requirements
- R1: While `rst` is high at a clock edge, every output is driven low and both raster counters are returned to sample 0 of line 0 of field 0.
- R2: An output sample for position (h, v) is produced one cycle after the counters hold it. `vid_de` is high exactly when h < active width and v < active height. `vid_hblank` is high exactly when h >= active width.
- R3: `vid_hsync` is high exactly when hsync_start <= h < hsync_end.
- R4: `vid_vblank` is high exactly when v >= active height. `vid_vsync` is high exactly when vsync_start <= v < vsync_end.
- R5: The horizontal counter wraps after h_total samples. In progressive mode (`interlaced`=0), a frame has v_total_f0 lines and `vid_field` stays 0. In interlaced mode, field 0 (`vid_field`=0) has v_total_f0 lines and is followed by field 1 (`vid_field`=1) with v_total_f1 lines.
- R6: `sof_pulse` is high for one output sample, at sample `sof_sample` of line `sof_line` in field 0. It is low at every other position.
- R7: `sof_locked` is low after reset and after each mode switch. It goes high with the last sample of the first complete frame generated in the current mode.
- R8: A `mode_load` pulse captures the mode inputs. The captured mode takes effect at the end of the current frame. `mode_change` is high for exactly one cycle, together with the last sample of the old frame. The next sample is position (0, 0), field 0, of the new mode.
- R9: `ref_clk_out` has a period of `refclk_div` cycles. It is high for the first floor(`refclk_div`/2) of those cycles and runs freely from reset. It is held low when `refclk_div` < 2.
- R10: `underflow_out` follows `underflow_sticky` through a two-stage synchronizer. A change on the input shows on the output after the second rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| h_active | input | 12 | Active samples per line |
| hsync_start | input | 12 | First sample of horizontal sync |
| hsync_end | input | 12 | First sample after horizontal sync |
| h_total | input | 12 | Total samples per line |
| v_active | input | 12 | Active lines per field |
| vsync_start | input | 12 | First line of vertical sync |
| vsync_end | input | 12 | First line after vertical sync |
| v_total_f0 | input | 12 | Lines in field 0 (whole frame when progressive) |
| v_total_f1 | input | 12 | Lines in field 1 |
| interlaced | input | 1 | 1 = two fields per frame |
| mode_load | input | 1 | Capture mode inputs as pending mode |
| sof_line | input | 12 | Line of the start-of-frame pulse |
| sof_sample | input | 12 | Sample of the start-of-frame pulse |
| refclk_div | input | 16 | Divider for the reference clock |
| underflow_sticky | input | 1 | Asynchronous sticky underflow status |
| vid_de | output | 1 | Active sample strobe |
| vid_hblank | output | 1 | Horizontal blanking |
| vid_hsync | output | 1 | Horizontal sync |
| vid_vblank | output | 1 | Vertical blanking |
| vid_vsync | output | 1 | Vertical sync |
| vid_field | output | 1 | Field flag |
| sof_pulse | output | 1 | Start-of-frame pulse |
| sof_locked | output | 1 | Start-of-frame valid |
| ref_clk_out | output | 1 | Divided clock reference |
| mode_change | output | 1 | One-cycle warning before new timing |
| underflow_out | output | 1 | Synchronized underflow |

## Verification
The first pattern is a small progressive mode. Sampled points sit on each active/blanking edge and each sync edge of a frame, which tells apart off-by-one errors in the inclusive and exclusive bounds of each interval. The bench then loads an interlaced mode with different line totals per field. This separates a switch made at the frame boundary from one made at a line or field boundary, and shows whether each field uses its own line total. Start-of-frame is probed at its target position, at the positions on either side, and at the same position in field 1. Lock is probed across a mode switch. The divider and the synchronizer are checked at their period edges and latency edges.

// File: rtl/vrg_pkg.sv
package vrg_pkg;
  localparam int unsigned CNT_W = 12;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    cnt_t h_act;
    cnt_t hs_beg;
    cnt_t hs_end;
    cnt_t h_tot;
    cnt_t v_act;
    cnt_t vs_beg;
    cnt_t vs_end;
    cnt_t v_tot0;
    cnt_t v_tot1;
    logic ilace;
  } mode_t;

  // half-open interval membership [beg, fin)
  function automatic logic span_hit(cnt_t x, cnt_t beg, cnt_t fin);
    return (x >= beg) && (x < fin);
  endfunction

  // last line index of the given field in a mode
  function automatic cnt_t field_last_line(mode_t m, logic fld);
    return (m.ilace && fld) ? cnt_t'(m.v_tot1 - 1'b1) : cnt_t'(m.v_tot0 - 1'b1);
  endfunction
endpackage

// File: rtl/vrg_timebase.sv
module vrg_timebase
  import vrg_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  mode_t mode_in,
  input  logic  mode_load,
  output cnt_t  h_cnt,
  output cnt_t  v_cnt,
  output logic  fld_cnt,
  output mode_t cur,
  output logic  frame_end,
  output logic  apply,
  output logic  mode_chg
);
  mode_t nxt;
  logic  pend;
  logic  line_end;
  logic  field_end;

  assign line_end  = (h_cnt == cnt_t'(cur.h_tot - 1'b1));
  assign field_end = line_end && (v_cnt == field_last_line(cur, fld_cnt));
  assign frame_end = field_end && (!cur.ilace || fld_cnt);
  assign apply     = frame_end && pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      h_cnt    <= '0;
      v_cnt    <= '0;
      fld_cnt  <= 1'b0;
      cur      <= mode_in;
      nxt      <= mode_in;
      pend     <= 1'b0;
      mode_chg <= 1'b0;
    end else begin
      mode_chg <= apply;
      if (mode_load) begin
        nxt  <= mode_in;
        pend <= 1'b1;
      end else if (apply) begin
        pend <= 1'b0;
      end
      if (line_end) begin
        h_cnt <= '0;
        if (field_end) begin
          v_cnt <= '0;
          if (apply) begin
            cur     <= nxt;
            fld_cnt <= 1'b0;
          end else begin
            fld_cnt <= cur.ilace ? ~fld_cnt : 1'b0;
          end
        end else begin
          v_cnt <= v_cnt + 1'b1;
        end
      end else begin
        h_cnt <= h_cnt + 1'b1;
      end
    end
  end

  p_hcnt_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    h_cnt < cur.h_tot);
  p_chg_single_r8: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> !mode_chg);
  p_chg_home_r8: assert property (@(posedge clk) disable iff (rst)
    mode_chg |-> (h_cnt == '0 && v_cnt == '0 && !fld_cnt));
endmodule

// File: rtl/vrg_strobes.sv
module vrg_strobes
  import vrg_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  cnt_t  h_cnt,
  input  cnt_t  v_cnt,
  input  logic  fld_cnt,
  input  mode_t cur,
  output logic  de_o,
  output logic  hb_o,
  output logic  hs_o,
  output logic  vb_o,
  output logic  vs_o,
  output logic  fld_o
);
  logic h_in_act;
  logic v_in_act;

  assign h_in_act = (h_cnt < cur.h_act);
  assign v_in_act = (v_cnt < cur.v_act);

  always_ff @(posedge clk) begin
    if (rst) begin
      de_o  <= 1'b0;
      hb_o  <= 1'b0;
      hs_o  <= 1'b0;
      vb_o  <= 1'b0;
      vs_o  <= 1'b0;
      fld_o <= 1'b0;
    end else begin
      de_o  <= h_in_act && v_in_act;
      hb_o  <= !h_in_act;
      hs_o  <= span_hit(h_cnt, cur.hs_beg, cur.hs_end);
      vb_o  <= !v_in_act;
      vs_o  <= span_hit(v_cnt, cur.vs_beg, cur.vs_end);
      fld_o <= cur.ilace && fld_cnt;
    end
  end

  p_de_active_r2: assert property (@(posedge clk) disable iff (rst)
    de_o |-> (!hb_o && !vb_o));
endmodule

// File: rtl/vrg_frame_ref.sv
module vrg_frame_ref
  import vrg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  cnt_t h_cnt,
  input  cnt_t v_cnt,
  input  logic fld_cnt,
  input  logic frame_end,
  input  logic apply,
  input  cnt_t sof_line,
  input  cnt_t sof_sample,
  output logic sof_o,
  output logic lock_o
);
  logic at_mark;

  assign at_mark = (h_cnt == sof_sample) && (v_cnt == sof_line) && !fld_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sof_o  <= 1'b0;
      lock_o <= 1'b0;
    end else begin
      sof_o <= at_mark;
      if (apply)          lock_o <= 1'b0;
      else if (frame_end) lock_o <= 1'b1;
    end
  end

  p_sof_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    sof_o |=> !sof_o);
endmodule

// File: rtl/vrg_divider.sv
module vrg_divider #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             ref_o
);
  logic [DIV_W-1:0] dcnt;
  logic             div_ok;

  assign div_ok = (div >= DIV_W'(2));

  always_ff @(posedge clk) begin
    if (rst) begin
      dcnt  <= '0;
      ref_o <= 1'b0;
    end else begin
      if (!div_ok || dcnt >= div - 1'b1) dcnt <= '0;
      else                               dcnt <= dcnt + 1'b1;
      ref_o <= div_ok && (dcnt < (div >> 1));
    end
  end

  p_ref_low_r9: assert property (@(posedge clk) disable iff (rst)
    !div_ok |=> !ref_o);
endmodule

// File: rtl/vrg_sync.sv
module vrg_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b0;
    else     chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= 1'b0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/vid_raster_gen.sv
module vid_raster_gen
  import vrg_pkg::*;
#(
  parameter int unsigned DIV_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] h_active,
  input  logic [CNT_W-1:0] hsync_start,
  input  logic [CNT_W-1:0] hsync_end,
  input  logic [CNT_W-1:0] h_total,
  input  logic [CNT_W-1:0] v_active,
  input  logic [CNT_W-1:0] vsync_start,
  input  logic [CNT_W-1:0] vsync_end,
  input  logic [CNT_W-1:0] v_total_f0,
  input  logic [CNT_W-1:0] v_total_f1,
  input  logic             interlaced,
  input  logic             mode_load,
  input  logic [CNT_W-1:0] sof_line,
  input  logic [CNT_W-1:0] sof_sample,
  input  logic [DIV_W-1:0] refclk_div,
  input  logic             underflow_sticky,
  output logic             vid_de,
  output logic             vid_hblank,
  output logic             vid_hsync,
  output logic             vid_vblank,
  output logic             vid_vsync,
  output logic             vid_field,
  output logic             sof_pulse,
  output logic             sof_locked,
  output logic             ref_clk_out,
  output logic             mode_change,
  output logic             underflow_out
);
  mode_t mode_in;
  mode_t cur;
  cnt_t  h_cnt;
  cnt_t  v_cnt;
  logic  fld_cnt;
  logic  frame_end;
  logic  apply;

  assign mode_in = '{h_act: h_active, hs_beg: hsync_start, hs_end: hsync_end,
                     h_tot: h_total, v_act: v_active, vs_beg: vsync_start,
                     vs_end: vsync_end, v_tot0: v_total_f0, v_tot1: v_total_f1,
                     ilace: interlaced};

  vrg_timebase u_tb (
    .clk, .rst, .mode_in, .mode_load,
    .h_cnt, .v_cnt, .fld_cnt, .cur, .frame_end, .apply,
    .mode_chg(mode_change)
  );

  vrg_strobes u_st (
    .clk, .rst, .h_cnt, .v_cnt, .fld_cnt, .cur,
    .de_o(vid_de), .hb_o(vid_hblank), .hs_o(vid_hsync),
    .vb_o(vid_vblank), .vs_o(vid_vsync), .fld_o(vid_field)
  );

  vrg_frame_ref u_fr (
    .clk, .rst, .h_cnt, .v_cnt, .fld_cnt, .frame_end, .apply,
    .sof_line, .sof_sample, .sof_o(sof_pulse), .lock_o(sof_locked)
  );

  vrg_divider #(.DIV_W(DIV_W)) u_dv (
    .clk, .rst, .div(refclk_div), .ref_o(ref_clk_out)
  );

  vrg_sync #(.STAGES(SYNC_STAGES)) u_sy (
    .clk, .rst, .d(underflow_sticky), .q(underflow_out)
  );

  p_lock_drop_r7: assert property (@(posedge clk) disable iff (rst)
    mode_change |-> !sof_locked);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> !(vid_de || vid_hsync || vid_vsync || sof_pulse || mode_change));
endmodule

// File: tb/sim_vid_raster_gen.sv
module sim_vid_raster_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] h_active, hsync_start, hsync_end, h_total;
  logic [11:0] v_active, vsync_start, vsync_end, v_total_f0, v_total_f1;
  logic        interlaced, mode_load, underflow_sticky;
  logic [11:0] sof_line, sof_sample;
  logic [15:0] refclk_div;
  logic vid_de, vid_hblank, vid_hsync, vid_vblank, vid_vsync, vid_field;
  logic sof_pulse, sof_locked, ref_clk_out, mode_change, underflow_out;

  int checks = 0;
  int fails  = 0;
  int pos    = -1;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  vid_raster_gen u0 (.*);

  // entry: {h[7:0], v[7:0], de, hblank, hsync, vblank, vsync}; mode A
  localparam logic [20:0] VEC [13] = '{
    {8'd0,  8'd0, 5'b10000}, {8'd7,  8'd0, 5'b10000},
    {8'd8,  8'd0, 5'b01000}, {8'd9,  8'd0, 5'b01000},
    {8'd10, 8'd0, 5'b01100}, {8'd11, 8'd1, 5'b01100},
    {8'd12, 8'd1, 5'b01000}, {8'd15, 8'd3, 5'b01000},
    {8'd0,  8'd4, 5'b00010}, {8'd3,  8'd5, 5'b00011},
    {8'd11, 8'd5, 5'b01111}, {8'd0,  8'd6, 5'b00010},
    {8'd15, 8'd7, 5'b01010}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s at pos %0d: got=%0d exp=%0d", tag, pos, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    pos++;
  endtask

  task automatic go(input int p);
    while (pos < p) tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    // mode A: 16 x 8 progressive
    h_active = 8;  hsync_start = 10; hsync_end = 12; h_total = 16;
    v_active = 4;  vsync_start = 5;  vsync_end = 6;  v_total_f0 = 8; v_total_f1 = 8;
    interlaced = 0; mode_load = 0; underflow_sticky = 0;
    sof_line = 2; sof_sample = 3; refclk_div = 16;
    repeat (3) @(negedge clk);
    // R1: outputs low while in reset
    chk("R1 de", vid_de, 0);
    chk("R1 hblank", vid_hblank, 0);
    chk("R1 vblank", vid_vblank, 0);
    chk("R1 lock", sof_locked, 0);
    chk("R1 ref", ref_clk_out, 0);
    rst = 1'b0;

    for (int i = 0; i < 13; i++) begin
      go(int'(VEC[i][12:5]) * 16 + int'(VEC[i][20:13]));
      chk("R2 de", vid_de, VEC[i][4]);
      chk("R2 hblank", vid_hblank, VEC[i][3]);
      chk("R3 hsync", vid_hsync, VEC[i][2]);
      chk("R4 vblank", vid_vblank, VEC[i][1]);
      chk("R4 vsync", vid_vsync, VEC[i][0]);
      chk("R5 progressive field", vid_field, 0);
      if (i == 3) begin
        chk("R9 ref low half", ref_clk_out, 0);
        chk("R7 unlocked first frame", sof_locked, 0);
      end
    end

    go(130); chk("R7 locked after frame", sof_locked, 1);
    go(131); chk("R9 ref high half", ref_clk_out, 1);
    go(140); chk("R9 ref low", ref_clk_out, 0);
    go(144); chk("R9 ref period wrap", ref_clk_out, 1);

    // load mode B: 12 samples, interlaced 6 + 5 lines
    go(150);
    h_active = 6; hsync_start = 7; hsync_end = 9; h_total = 12;
    v_active = 4; vsync_start = 4; vsync_end = 5; v_total_f0 = 6; v_total_f1 = 5;
    interlaced = 1; mode_load = 1;
    tick();
    mode_load = 0;

    go(162); chk("R6 sof before", sof_pulse, 0);
    go(163); chk("R6 sof at mark", sof_pulse, 1);
    go(164); chk("R6 sof after", sof_pulse, 0);
    chk("R8 old mode held mid-frame", vid_hblank, 0);

    go(170);
    underflow_sticky = 1;
    tick(); chk("R10 underflow one edge", underflow_out, 0);
    tick(); chk("R10 underflow two edges", underflow_out, 1);

    go(254); chk("R8 no early change", mode_change, 0);
    go(255); chk("R8 change flag", mode_change, 1);
    chk("R7 lock drops on switch", sof_locked, 0);
    chk("R5 old frame last line", vid_vblank, 1);
    go(256); chk("R8 change single", mode_change, 0);
    chk("R8 new origin de", vid_de, 1);
    chk("R5 new field 0", vid_field, 0);
    go(262); chk("R2 mode B hblank", vid_hblank, 1);
    go(263); chk("R3 mode B hsync", vid_hsync, 1);
    go(265); chk("R3 mode B hsync end", vid_hsync, 0);
    go(283); chk("R6 sof field 0", sof_pulse, 1);
    go(300); chk("R7 unlocked new mode", sof_locked, 0);
    go(327); chk("R5 field 0 last", vid_field, 0);
    go(328); chk("R5 field 1 first", vid_field, 1);
    chk("R2 field 1 line 0 active", vid_de, 1);
    go(355); chk("R6 no sof field 1", sof_pulse, 0);
    go(364); chk("R4 field 1 line 3 active", vid_vblank, 0);
    go(376); chk("R4 field 1 line 4 blank", vid_vblank, 1);
    chk("R4 field 1 vsync", vid_vsync, 1);
    go(387); chk("R5 field 1 last", vid_field, 1);
    chk("R7 relock", sof_locked, 1);
    go(388); chk("R5 frame wrap field 0", vid_field, 0);
    chk("R8 no second change", mode_change, 0);

    // R9: divisor below 2 holds the reference low
    refclk_div = 1;
    tick(); tick();
    chk("R9 div<2 low", ref_clk_out, 0);

    // R1: reset mid-run
    rst = 1'b1;
    tick();
    chk("R1 reset de", vid_de, 0);
    chk("R1 reset underflow", underflow_out, 0);
    chk("R1 reset field", vid_field, 0);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end
endmodule